// File: doc/BRIEF.md
# Port Traffic Status LED Driver

This block drives four active-low indicator pins, a receive LED and a transmit LED for each of two cell ports. Each LED shows one of three states. An idle port has both LEDs lit steadily. A direction that carries non-null cells flashes its LED. A port whose physical layer reports an alarm has its transmit LED lit and its receive LED dark. The cell datapath reports each cell with a one-cycle strobe and a null flag sampled with it. A null cell is one whose first four header bytes are 00 00 00 01. Null cells never count as traffic.

One free-running timebase, set by a programmable divider, supplies the flash phase for all four LEDs. A direction stays in the traffic state for as long as non-null cells keep arriving within each full flash period. After one full period with no non-null cell it returns to idle. A mode input hands the four pins to general purpose I/O. In that mode software-supplied values and output enables drive the pins, and the pin levels are always readable through a registered input path. The alarm inputs change nothing except the LEDs.

Top module: `port_led_status`

## Requirements
- R1: While `rst_n` is low, all four `pin_out` bits are 0 (lit), all four `pin_oe` bits are 1 when `gpio_mode` is 0, and `gpio_in` is 0.
- R2: A direction with no traffic, on a port with no alarm, drives its pin to 0 continuously. Pin index 2p is the receive LED of port p and 2p+1 is its transmit LED.
- R3: A direction in the traffic state drives its pin from the flash phase. The pin is 0 during the first half of each flash period and 1 during the second half.
- R4: One cycle after `phy_alarm[p]` is seen high, pin 2p+1 is 0 and pin 2p is 1, whether or not there is traffic.
- R5: A cell strobe whose null flag is 1 never moves a direction out of idle.
- R6: Alarm outranks traffic and traffic outranks idle. Each direction of each port is decided independently of all the others.
- R7: A non-null cell puts its direction in the traffic state from the next cycle. At the end of each full flash period the direction stays in traffic only if a non-null cell arrived during that period. Otherwise it returns to idle.
- R8: Each flash half-period lasts `flash_div`+1 cycles. The first half after reset is the lit half. If `flash_div` is lowered below the running count, the current half ends on the next cycle.
- R9: While `gpio_mode` is 1, `pin_out` equals `gpio_out` and `pin_oe` equals `gpio_oe`. The LED state keeps evolving underneath.
- R10: `gpio_in` returns the value `pin_in` had one clock earlier, in both modes.
- R11: Reset is released synchronously. After `rst_n` rises, the LED pins keep their reset value through two rising edges and first reflect the inputs after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_cell_stb | input | NPORTS | Receive cell strobe per port |
| rx_cell_null | input | NPORTS | Receive cell is a null cell, sampled with the strobe |
| tx_cell_stb | input | NPORTS | Transmit cell strobe per port |
| tx_cell_null | input | NPORTS | Transmit cell is a null cell, sampled with the strobe |
| phy_alarm | input | NPORTS | Physical layer alarm per port |
| flash_div | input | DIV_W | Flash half-period length minus one, in cycles |
| gpio_mode | input | 1 | 1 hands the pins to general purpose I/O |
| gpio_out | input | 2*NPORTS | Pin output values in I/O mode |
| gpio_oe | input | 2*NPORTS | Pin output enables in I/O mode |
| pin_in | input | 2*NPORTS | Level seen on the pins |
| pin_out | output | 2*NPORTS | Pin output values, active-low in LED mode |
| pin_oe | output | 2*NPORTS | Pin output enables |
| gpio_in | output | 2*NPORTS | Registered pin levels |

## Verification
The bound checker covers these on every cycle: the alarm pattern, steady idle lighting, the link between flashing pins and the shared phase, null cells that leave an idle direction idle, the I/O-mode pass-through, and the one-cycle input readback. Only the bench's scenarios can show the rest. These are the length of traffic hold and the return to idle after a quiet period, the half-period length under several divider values including a divider lowered mid-count, and the three-edge reset release. A cycle model running under random cell, alarm, divider and mode traffic shows them, together with directed cases for null-only streams and independent directions.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic [1:0] {
    LS_IDLE    = 2'd0,
    LS_TRAFFIC = 2'd1,
    LS_ALARM   = 2'd2
  } led_state_e;

  localparam logic LED_ON  = 1'b0;
  localparam logic LED_OFF = 1'b1;

  // Priority: alarm, then traffic, then idle.
  function automatic led_state_e pick_state(input logic alarm, input logic active);
    if (alarm)  return LS_ALARM;
    if (active) return LS_TRAFFIC;
    return LS_IDLE;
  endfunction

  // Pin level for one direction; is_tx selects the alarm polarity.
  function automatic logic led_level(input led_state_e st, input logic is_tx,
                                     input logic phase);
    logic lvl;
    case (st)
      LS_ALARM:   lvl = is_tx ? LED_ON : LED_OFF;
      LS_TRAFFIC: lvl = phase ? LED_OFF : LED_ON;
      default:    lvl = LED_ON;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/led_flash_timebase.sv
module led_flash_timebase #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [DIV_W-1:0] flash_div,
  output logic             phase,
  output logic             period_end
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             phase_d;
  logic             half_end;

  always_comb begin
    half_end   = (cnt_q >= flash_div);
    cnt_d      = half_end ? '0 : cnt_q + 1'b1;
    phase_d    = half_end ? ~phase : phase;
    period_end = half_end & phase;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      phase <= phase_d;
    end
  end

endmodule

// File: rtl/led_activity_tracker.sv
module led_activity_tracker (
  input  logic clk,
  input  logic srst_n,
  input  logic cell_stb,
  input  logic cell_null,
  input  logic period_end,
  output logic active
);

  logic seen_q, seen_d, active_d;
  logic hit;

  always_comb begin
    hit = cell_stb & ~cell_null;
    if (period_end) begin
      active_d = seen_q | hit;
      seen_d   = 1'b0;
    end else begin
      active_d = active | hit;
      seen_d   = seen_q | hit;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      seen_q <= 1'b0;
      active <= 1'b0;
    end else begin
      seen_q <= seen_d;
      active <= active_d;
    end
  end

endmodule

// File: rtl/led_port_encoder.sv
module led_port_encoder
  import led_status_pkg::*;
(
  input  logic       alarm,
  input  logic       rx_active,
  input  logic       tx_active,
  input  logic       phase,
  output logic [1:0] led_n_nxt
);

  led_state_e rx_st, tx_st;

  always_comb begin
    rx_st        = pick_state(alarm, rx_active);
    tx_st        = pick_state(alarm, tx_active);
    led_n_nxt[0] = led_level(rx_st, 1'b0, phase);
    led_n_nxt[1] = led_level(tx_st, 1'b1, phase);
  end

endmodule

// File: rtl/port_led_status.sv
module port_led_status #(
  parameter int NPORTS = 2,
  parameter int DIV_W  = 16,
  localparam int NPINS = 2 * NPORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] rx_cell_stb,
  input  logic [NPORTS-1:0] rx_cell_null,
  input  logic [NPORTS-1:0] tx_cell_stb,
  input  logic [NPORTS-1:0] tx_cell_null,
  input  logic [NPORTS-1:0] phy_alarm,
  input  logic [DIV_W-1:0]  flash_div,
  input  logic              gpio_mode,
  input  logic [NPINS-1:0]  gpio_out,
  input  logic [NPINS-1:0]  gpio_oe,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  gpio_in
);

  logic [1:0]       rsync_q;
  logic             srst_n;
  logic             phase;
  logic             period_end;
  logic [NPINS-1:0] dir_stb, dir_null, dir_active;
  logic [NPINS-1:0] led_n_d, led_n_q;
  logic [NPINS-1:0] gpio_in_d;

  // Reset synchroniser: asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  led_flash_timebase #(.DIV_W(DIV_W)) timebase_i (
    .clk        (clk),
    .srst_n     (srst_n),
    .flash_div  (flash_div),
    .phase      (phase),
    .period_end (period_end)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign dir_stb[2*p]    = rx_cell_stb[p];
    assign dir_null[2*p]   = rx_cell_null[p];
    assign dir_stb[2*p+1]  = tx_cell_stb[p];
    assign dir_null[2*p+1] = tx_cell_null[p];

    led_port_encoder enc_i (
      .alarm     (phy_alarm[p]),
      .rx_active (dir_active[2*p]),
      .tx_active (dir_active[2*p+1]),
      .phase     (phase),
      .led_n_nxt (led_n_d[2*p+1:2*p])
    );
  end

  for (genvar d = 0; d < NPINS; d++) begin : g_dir
    led_activity_tracker trk_i (
      .clk        (clk),
      .srst_n     (srst_n),
      .cell_stb   (dir_stb[d]),
      .cell_null  (dir_null[d]),
      .period_end (period_end),
      .active     (dir_active[d])
    );
  end

  always_comb begin
    gpio_in_d = pin_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      led_n_q <= '0;
      gpio_in <= '0;
    end else begin
      led_n_q <= led_n_d;
      gpio_in <= gpio_in_d;
    end
  end

  always_comb begin
    if (gpio_mode) begin
      pin_out = gpio_out;
      pin_oe  = gpio_oe;
    end else begin
      pin_out = led_n_q;
      pin_oe  = '1;
    end
  end

endmodule

// File: rtl/led_status_checker.sv
module led_status_checker #(
  parameter int NPORTS = 2,
  localparam int NPINS = 2 * NPORTS
) (
  input logic              clk,
  input logic              srst_n,
  input logic [NPORTS-1:0] rx_cell_stb,
  input logic [NPORTS-1:0] rx_cell_null,
  input logic [NPORTS-1:0] phy_alarm,
  input logic              gpio_mode,
  input logic [NPINS-1:0]  gpio_out,
  input logic [NPINS-1:0]  gpio_oe,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  gpio_in,
  input logic [NPINS-1:0]  dir_active,
  input logic              phase
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    assert_alarm_pattern_R4: assert property (@(posedge clk) disable iff (!srst_n)
      phy_alarm[p] |=> (gpio_mode || (pin_out[2*p] && !pin_out[2*p+1])));

    assert_idle_rx_lit_R2: assert property (@(posedge clk) disable iff (!srst_n)
      (!phy_alarm[p] && !dir_active[2*p]) |=> (gpio_mode || !pin_out[2*p]));

    assert_idle_tx_lit_R2: assert property (@(posedge clk) disable iff (!srst_n)
      (!phy_alarm[p] && !dir_active[2*p+1]) |=> (gpio_mode || !pin_out[2*p+1]));

    assert_flash_rx_R3: assert property (@(posedge clk) disable iff (!srst_n)
      (!phy_alarm[p] && dir_active[2*p]) |=> (gpio_mode || pin_out[2*p] == $past(phase)));

    assert_flash_tx_R3: assert property (@(posedge clk) disable iff (!srst_n)
      (!phy_alarm[p] && dir_active[2*p+1]) |=> (gpio_mode || pin_out[2*p+1] == $past(phase)));

    assert_null_no_traffic_R5: assert property (@(posedge clk) disable iff (!srst_n)
      (rx_cell_stb[p] && rx_cell_null[p] && !dir_active[2*p]) |=> !dir_active[2*p]);
  end

  assert_gpio_drive_R9: assert property (@(posedge clk) disable iff (!srst_n)
    gpio_mode |-> (pin_out == gpio_out && pin_oe == gpio_oe));

  assert_led_drive_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !gpio_mode |-> (&pin_oe));

  assert_readback_R10: assert property (@(posedge clk) disable iff (!srst_n)
    srst_n |=> (gpio_in == $past(pin_in)));

endmodule

bind port_led_status led_status_checker #(.NPORTS(NPORTS)) chk_i (
  .clk          (clk),
  .srst_n       (srst_n),
  .rx_cell_stb  (rx_cell_stb),
  .rx_cell_null (rx_cell_null),
  .phy_alarm    (phy_alarm),
  .gpio_mode    (gpio_mode),
  .gpio_out     (gpio_out),
  .gpio_oe      (gpio_oe),
  .pin_in       (pin_in),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .gpio_in      (gpio_in),
  .dir_active   (dir_active),
  .phase        (phase)
);

// File: tb/port_led_status_tb_top.sv
`timescale 1ns/100ps
module port_led_status_tb_top;

  localparam int NP = 2;
  localparam int NPIN = 4;
  localparam int DW = 16;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   rx_cell_stb, rx_cell_null, tx_cell_stb, tx_cell_null, phy_alarm;
  logic [DW-1:0]   flash_div;
  logic            gpio_mode;
  logic [NPIN-1:0] gpio_out, gpio_oe, pin_in;
  logic [NPIN-1:0] pin_out, pin_oe, gpio_in;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 0;
  bit done     = 0;

  port_led_status #(.NPORTS(NP), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_cell_stb(rx_cell_stb), .rx_cell_null(rx_cell_null),
    .tx_cell_stb(tx_cell_stb), .tx_cell_null(tx_cell_null),
    .phy_alarm(phy_alarm), .flash_div(flash_div), .gpio_mode(gpio_mode),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .gpio_in(gpio_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Reference model built from the requirements.
  logic [DW-1:0]   m_cnt;
  logic            m_phase, m_rs0, m_rs1;
  logic [NPIN-1:0] m_seen, m_act, m_led, m_gin;

  function automatic logic [NPIN-1:0] dir_hits();
    logic [NPIN-1:0] h;
    for (int p = 0; p < NP; p++) begin
      h[2*p]   = rx_cell_stb[p] & ~rx_cell_null[p];
      h[2*p+1] = tx_cell_stb[p] & ~tx_cell_null[p];
    end
    return h;
  endfunction

  function automatic logic exp_level(input logic alarm, input logic is_tx,
                                     input logic act, input logic ph);
    if (alarm) return is_tx ? 1'b0 : 1'b1;   // R4 / R6
    if (act)   return ph;                     // R3
    return 1'b0;                              // R2
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_phase = 0; m_rs0 = 0; m_rs1 = 0;
      m_seen = '0; m_act = '0; m_led = '0; m_gin = '0;
    end else begin
      if (m_rs1) begin
        logic half_end, pend;
        logic [NPIN-1:0] h, n_act, n_seen, n_led;
        half_end = (m_cnt >= flash_div);
        pend = half_end && m_phase;
        h = dir_hits();
        for (int d = 0; d < NPIN; d++) begin
          n_act[d]  = pend ? (m_seen[d] | h[d]) : (m_act[d] | h[d]);
          n_seen[d] = pend ? 1'b0 : (m_seen[d] | h[d]);
          n_led[d]  = exp_level(phy_alarm[d/2], d[0], m_act[d], m_phase);
        end
        m_act = n_act; m_seen = n_seen; m_led = n_led; m_gin = pin_in;
        m_cnt = half_end ? '0 : m_cnt + 1'b1;
        m_phase = m_phase ^ half_end;
      end
      m_rs1 = m_rs0;
      m_rs0 = 1'b1;
    end
  end

  // Continuous comparison against the model, before inputs change.
  always @(negedge clk) begin
    if (cmp_en) begin
      if (gpio_mode) begin
        check("R9 pin_out", pin_out, gpio_out);
        check("R9 pin_oe", pin_oe, gpio_oe);
      end else begin
        check("R2 R3 R4 R6 R7 R8 led", pin_out, m_led);
        check("R1 led oe", pin_oe, 4'hF);
      end
      check("R10 readback", gpio_in, m_gin);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_test();
  end

  task automatic idle_inputs();
    rx_cell_stb = '0; rx_cell_null = '0; tx_cell_stb = '0; tx_cell_null = '0;
  endtask

  initial begin
    int toggles;
    logic prev;
    void'($urandom(32'h1ED5));
    rst_n = 0; idle_inputs(); phy_alarm = '1; flash_div = 16'd3;
    gpio_mode = 0; gpio_out = '0; gpio_oe = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pins", pin_out, 4'h0);
    check("R1 reset oe", pin_oe, 4'hF);
    check("R1 reset readback", gpio_in, 4'h0);
    cmp_en = 1;
    #1 rst_n = 1;
    @(negedge clk); check("R11 edge1 held", pin_out, 4'h0);
    @(negedge clk); check("R11 edge2 held", pin_out, 4'h0);
    @(negedge clk); check("R11 edge3 alarm", pin_out, 4'b0101);
    #1 phy_alarm = '0;
    repeat (20) @(negedge clk);
    check("R2 idle", pin_out, 4'h0);

    // Null cells only: must stay idle.
    for (int i = 0; i < 40; i++) begin
      #1 rx_cell_stb = '1; tx_cell_stb = '1; rx_cell_null = '1; tx_cell_null = '1;
      @(negedge clk);
      check("R5 null cells stay idle", pin_out, 4'h0);
    end
    #1 idle_inputs();

    // Alarm on port 1 with traffic on its directions.
    #0 phy_alarm = 2'b10; rx_cell_stb = 2'b10; tx_cell_stb = 2'b10;
    @(negedge clk); #1 idle_inputs();
    repeat (5) @(negedge clk);
    check("R4 R6 alarm beats traffic", pin_out[3:2], 2'b01);
    #1 phy_alarm = '0;
    repeat (20) @(negedge clk);

    // One non-null receive cell on port 0: rx flashes, tx stays lit.
    #1 rx_cell_stb = 2'b01;
    @(negedge clk); #1 idle_inputs();
    @(negedge clk);
    prev = pin_out[0]; toggles = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pin_out[0] !== prev) toggles++;
      prev = pin_out[0];
      check("R6 tx independent of rx", pin_out[1], 1'b0);
    end
    check("R3 rx flashes", (toggles >= 1), 1'b1);
    repeat (30) @(negedge clk);
    check("R7 reverts to idle", pin_out, 4'h0);

    // Divider lowered below the running count.
    #1 flash_div = 16'd40;
    repeat (25) @(negedge clk);
    #1 flash_div = 16'd2;
    repeat (30) @(negedge clk);
    check("R8 after divider change", pin_out, 4'h0);

    // GPIO mode.
    #1 gpio_mode = 1; gpio_out = 4'hA; gpio_oe = 4'h5; pin_in = 4'hC;
    @(negedge clk);
    check("R9 gpio drive", pin_out, 4'hA);
    check("R10 gpio readback", gpio_in, 4'hC);
    #1 gpio_mode = 0;

    // Random phase.
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      #1;
      for (int p = 0; p < NP; p++) begin
        rx_cell_stb[p]  = ($urandom % 6) == 0;
        tx_cell_stb[p]  = ($urandom % 6) == 0;
        rx_cell_null[p] = ($urandom % 3) == 0;
        tx_cell_null[p] = ($urandom % 3) == 0;
        if (($urandom % 150) == 0) phy_alarm[p] = ~phy_alarm[p];
      end
      if (($urandom % 400) == 0) flash_div = 16'($urandom % 7);
      if (($urandom % 300) == 0) gpio_mode = ~gpio_mode;
      gpio_out = 4'($urandom); gpio_oe = 4'($urandom); pin_in = 4'($urandom);
    end
    @(negedge clk);
    finish_test();
  end

endmodule